// File: doc/BRIEF.md
# Segmented-Bitline Row Cache Manager

This block is the per-subarray control logic for a DRAM array whose bitlines are split by an isolation switch into a short, fast near segment of 32 rows and a long, slow far segment of 480 rows. The near rows act as a hardware-managed, fully associative, inclusive cache of far rows. The block accepts one row request at a time, addressed by far-row index, with a valid/ready handshake. It looks the row up in its tag store and emits a sequence of abstract commands. Each command carries a physical row number, the isolation-switch setting and a latency class.

A near hit reads through the short bitline. A fill copies a far row into a near row inside the array: the far row is opened, and the near row is then opened while the isolation switch is still on. This in-array copy costs only a small fixed extra delay over a normal activation. Every access closes with a precharge, so the array is left with no open row.

Two insertion policies are selectable with a mode input. In the plain policy every far miss is inserted into the least recently used slot. In the wait-only policy a miss is inserted only if that row earlier held up a following request.

Top module: `seg_row_cache_mgr`

## Requirements
- R1: After reset, `reqReady` is 1, `cmdValid` and `done` are 0, all slots are empty, and the LRU order runs from slot 0 (oldest) to slot 31 (newest), so the first fills go to slots 0, 1, 2 and so on in that order.
- R2: A read whose row is cached issues a single activation with op code 0 (near) to physical row equal to the slot number, with `cmdIsoOn`=0 and `cmdSlow`=0. `done` rises NEAR_LAT cycles after that activation, with `doneHit`=1.
- R3: A miss that is not inserted issues a single activation with op code 1 (far) to physical row NEAR_ROWS + request row, with `cmdIsoOn`=1 and `cmdSlow`=1. `done` rises FAR_LAT cycles later, with `doneHit`=0.
- R4: A fill issues op 1 (far source row) and, in the very next cycle, op 2 (link-near) to the destination slot with `cmdIsoOn`=1 and `cmdSlow`=1. `done` rises FAR_LAT+MIG_EXTRA cycles after the first activation.
- R5: Every access ends with exactly one command with op code 3 (precharge), issued in the same cycle as `done`. `done` is a one-cycle pulse.
- R6: With `modeWaitOnly`=0, every miss is inserted into the slot that was least recently used.
- R7: With `modeWaitOnly`=1, a missing row is inserted only if it is marked. A row is marked when `reqValid` is high during any busy cycle of an access to it. The mark is cleared by that row's next miss, whether or not the row is inserted.
- R8: A write whose row is cached issues op 1 to the far row, then op 2 to its slot in the next cycle. The latency is FAR_LAT+MIG_EXTRA and `doneHit`=1, so both copies are updated.
- R9: `reqReady` is high only while no access is in progress. A request is taken on a cycle with `reqValid` and `reqReady` both high, and `reqReady` is low in the following cycle.
- R10: Any access to a cached row, and any fill, makes that slot the most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWaitOnly | input | 1 | 0: insert every miss; 1: insert only marked rows |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request taken this cycle |
| reqRow | input | 9 | Far-row index, 0 to FAR_ROWS-1 |
| reqWrite | input | 1 | Request is a write |
| cmdValid | output | 1 | Command issued this cycle |
| cmdOp | output | 2 | 0 near act, 1 far act, 2 link-near act, 3 precharge |
| cmdRow | output | 9 | Physical row: slots 0..31, far rows 32..511 |
| cmdIsoOn | output | 1 | Isolation switch closed (bitline joined) |
| cmdSlow | output | 1 | Latency class: 1 slow, 0 fast |
| done | output | 1 | Access complete (one cycle) |
| doneHit | output | 1 | Completed access hit the near segment |

## Verification
The checker assumes that `reqRow` never goes beyond the far-segment range while `reqValid` is high. The bench only draws row indices below 48, and uses a few fixed larger rows that stay well inside that range. The assertions also assume that `modeWaitOnly` is steady while an access runs, so the bench changes the mode only between accesses. The bench holds `reqValid` high through busy cycles only when it deliberately presents the next request early, and it mirrors each such overlap in its marking model.

// File: rtl/seg_rc_pkg.sv
package seg_rc_pkg;

  typedef enum logic [1:0] {
    OP_ACT_NEAR  = 2'd0,
    OP_ACT_FAR   = 2'd1,
    OP_LINK_NEAR = 2'd2,
    OP_PRECHARGE = 2'd3
  } cmd_op_e;

  typedef struct packed {
    logic latchReq;
    logic fill;
    logic touch;
    logic consumeMark;
    logic setMark;
  } dp_strobe_t;

endpackage

// File: rtl/rcm_tag_store.sv
module rcm_tag_store
  import seg_rc_pkg::*;
#(
  parameter int NEAR_ROWS = 32,
  parameter int FAR_ROWS  = 480,
  parameter int SLOT_W    = 5,
  parameter int FAR_W     = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [SLOT_W-1:0] slotSel,
  input  logic [FAR_W-1:0]  reqRow,
  input  logic              reqWrite,
  output logic [FAR_W-1:0]  curRow,
  output logic              curWrite,
  output logic              hit,
  output logic [SLOT_W-1:0] hitSlot,
  output logic [SLOT_W-1:0] victimSlot,
  output logic              curMarked
);

  localparam logic [SLOT_W-1:0] NEWEST = SLOT_W'(NEAR_ROWS - 1);

  logic [FAR_W-1:0]  tagArr   [NEAR_ROWS];
  logic [SLOT_W-1:0] ageArr   [NEAR_ROWS];
  logic [NEAR_ROWS-1:0] validVec;
  logic [NEAR_ROWS-1:0] matchVec;
  logic [FAR_ROWS-1:0]  markVec;

  // parallel tag compare, one comparator per slot
  for (genvar s = 0; s < NEAR_ROWS; s++) begin : g_cmp
    assign matchVec[s] = validVec[s] && (tagArr[s] == curRow);
  end

  always_comb begin
    hit     = |matchVec;
    hitSlot = '0;
    for (int s = NEAR_ROWS - 1; s >= 0; s--) begin
      if (matchVec[s]) hitSlot = SLOT_W'(s);
    end
  end

  always_comb begin
    victimSlot = '0;
    for (int s = NEAR_ROWS - 1; s >= 0; s--) begin
      if (ageArr[s] == '0) victimSlot = SLOT_W'(s);
    end
  end

  assign curMarked = markVec[curRow];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curRow   <= '0;
      curWrite <= 1'b0;
    end else if (strobe.latchReq) begin
      curRow   <= reqRow;
      curWrite <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
      for (int s = 0; s < NEAR_ROWS; s++) tagArr[s] <= '0;
    end else if (strobe.fill) begin
      validVec[slotSel] <= 1'b1;
      tagArr[slotSel]   <= curRow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NEAR_ROWS; s++) ageArr[s] <= SLOT_W'(s);
    end else if (strobe.touch) begin
      for (int s = 0; s < NEAR_ROWS; s++) begin
        if (ageArr[s] > ageArr[slotSel]) ageArr[s] <= ageArr[s] - 1'b1;
      end
      ageArr[slotSel] <= NEWEST;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      markVec <= '0;
    end else begin
      if (strobe.consumeMark) markVec[curRow] <= 1'b0;
      if (strobe.setMark)     markVec[curRow] <= 1'b1;
    end
  end

endmodule

// File: rtl/rcm_ctrl.sv
module rcm_ctrl
  import seg_rc_pkg::*;
#(
  parameter int NEAR_ROWS = 32,
  parameter int NEAR_LAT  = 6,
  parameter int FAR_LAT   = 14,
  parameter int MIG_EXTRA = 2,
  parameter int SLOT_W    = 5,
  parameter int FAR_W     = 9,
  parameter int ROW_W     = 9,
  parameter int CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWaitOnly,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [FAR_W-1:0]  curRow,
  input  logic              curWrite,
  input  logic              hit,
  input  logic [SLOT_W-1:0] hitSlot,
  input  logic [SLOT_W-1:0] victimSlot,
  input  logic              curMarked,
  output dp_strobe_t        strobe,
  output logic [SLOT_W-1:0] slotSel,
  output logic              cmdValid,
  output cmd_op_e           cmdOp,
  output logic [ROW_W-1:0]  cmdRow,
  output logic              cmdIsoOn,
  output logic              cmdSlow,
  output logic              done,
  output logic              doneHit
);

  localparam logic [CNT_W-1:0] NEAR_WAIT = CNT_W'(NEAR_LAT - 1);
  localparam logic [CNT_W-1:0] FAR_WAIT  = CNT_W'(FAR_LAT - 1);
  localparam logic [CNT_W-1:0] PAIR_WAIT = CNT_W'(FAR_LAT + MIG_EXTRA - 1);
  localparam logic [ROW_W-1:0] FAR_BASE  = ROW_W'(NEAR_ROWS);

  typedef enum logic [2:0] {ST_IDLE, ST_DECIDE, ST_LINK, ST_WAIT, ST_PRE} state_e;

  state_e            state, stateNxt;
  logic [CNT_W-1:0]  cnt, cntNxt;
  logic [SLOT_W-1:0] slotReg;
  logic              hitReg;
  logic              doInsert, doPair, nearRead;
  logic [SLOT_W-1:0] slotPick;

  assign nearRead = hit && !curWrite;
  assign doInsert = !hit && (!modeWaitOnly || curMarked);
  assign doPair   = (hit && curWrite) || doInsert;
  assign slotPick = hit ? hitSlot : victimSlot;
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    strobe   = '0;
    slotSel  = slotPick;
    cmdValid = 1'b0;
    cmdOp    = OP_PRECHARGE;
    cmdRow   = '0;
    cmdIsoOn = 1'b0;
    cmdSlow  = 1'b0;
    done     = 1'b0;
    doneHit  = 1'b0;
    strobe.setMark = (state != ST_IDLE) && reqValid;
    unique case (state)
      ST_IDLE: begin
        strobe.latchReq = reqValid;
        if (reqValid) stateNxt = ST_DECIDE;
      end
      ST_DECIDE: begin
        cmdValid           = 1'b1;
        strobe.touch       = hit || doInsert;
        strobe.fill        = doInsert;
        strobe.consumeMark = !hit;
        if (nearRead) begin
          cmdOp  = OP_ACT_NEAR;
          cmdRow = ROW_W'(slotPick);
          cntNxt = NEAR_WAIT;
        end else begin
          cmdOp    = OP_ACT_FAR;
          cmdRow   = FAR_BASE + ROW_W'(curRow);
          cmdIsoOn = 1'b1;
          cmdSlow  = 1'b1;
          cntNxt   = doPair ? PAIR_WAIT : FAR_WAIT;
        end
        stateNxt = doPair ? ST_LINK : ST_WAIT;
      end
      ST_LINK: begin
        cmdValid = 1'b1;
        cmdOp    = OP_LINK_NEAR;
        cmdRow   = ROW_W'(slotReg);
        cmdIsoOn = 1'b1;
        cmdSlow  = 1'b1;
        cntNxt   = cnt - 1'b1;
        stateNxt = (cnt == CNT_W'(1)) ? ST_PRE : ST_WAIT;
      end
      ST_WAIT: begin
        cntNxt   = cnt - 1'b1;
        stateNxt = (cnt == CNT_W'(1)) ? ST_PRE : ST_WAIT;
      end
      ST_PRE: begin
        cmdValid = 1'b1;
        cmdOp    = OP_PRECHARGE;
        done     = 1'b1;
        doneHit  = hitReg;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      slotReg <= '0;
      hitReg  <= 1'b0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      if (state == ST_DECIDE) begin
        slotReg <= slotPick;
        hitReg  <= hit;
      end
    end
  end

endmodule

// File: rtl/seg_row_cache_mgr.sv
module seg_row_cache_mgr
  import seg_rc_pkg::*;
#(
  parameter int NEAR_ROWS = 32,
  parameter int FAR_ROWS  = 480,
  parameter int NEAR_LAT  = 6,
  parameter int FAR_LAT   = 14,
  parameter int MIG_EXTRA = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWaitOnly,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic [8:0] reqRow,
  input  logic       reqWrite,
  output logic       cmdValid,
  output logic [1:0] cmdOp,
  output logic [8:0] cmdRow,
  output logic       cmdIsoOn,
  output logic       cmdSlow,
  output logic       done,
  output logic       doneHit
);

  localparam int SLOT_W = $clog2(NEAR_ROWS);
  localparam int FAR_W  = $clog2(FAR_ROWS);
  localparam int ROW_W  = $clog2(NEAR_ROWS + FAR_ROWS);
  localparam int CNT_W  = $clog2(FAR_LAT + MIG_EXTRA + 1);

  dp_strobe_t        strobe;
  logic [SLOT_W-1:0] slotSel, hitSlot, victimSlot;
  logic [FAR_W-1:0]  curRow;
  logic              curWrite, hit, curMarked;
  cmd_op_e           opEnum;

  rcm_tag_store #(
    .NEAR_ROWS(NEAR_ROWS), .FAR_ROWS(FAR_ROWS), .SLOT_W(SLOT_W), .FAR_W(FAR_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotSel(slotSel),
    .reqRow(reqRow[FAR_W-1:0]), .reqWrite(reqWrite),
    .curRow(curRow), .curWrite(curWrite), .hit(hit), .hitSlot(hitSlot),
    .victimSlot(victimSlot), .curMarked(curMarked)
  );

  rcm_ctrl #(
    .NEAR_ROWS(NEAR_ROWS), .NEAR_LAT(NEAR_LAT), .FAR_LAT(FAR_LAT),
    .MIG_EXTRA(MIG_EXTRA), .SLOT_W(SLOT_W), .FAR_W(FAR_W),
    .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeWaitOnly(modeWaitOnly), .reqValid(reqValid),
    .reqReady(reqReady), .curRow(curRow), .curWrite(curWrite), .hit(hit),
    .hitSlot(hitSlot), .victimSlot(victimSlot), .curMarked(curMarked),
    .strobe(strobe), .slotSel(slotSel), .cmdValid(cmdValid), .cmdOp(opEnum),
    .cmdRow(cmdRow), .cmdIsoOn(cmdIsoOn), .cmdSlow(cmdSlow),
    .done(done), .doneHit(doneHit)
  );

  assign cmdOp = opEnum;

endmodule

// File: rtl/seg_row_cache_mgr_chk.sv
module seg_row_cache_mgr_chk #(
  parameter int NEAR_ROWS = 32,
  parameter int FAR_ROWS  = 480
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic [8:0] reqRow,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic [8:0] cmdRow,
  input logic       cmdIsoOn,
  input logic       cmdSlow,
  input logic       done
);

  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (32'(reqRow) < FAR_ROWS)); // R3
  AST_NEAR_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd0) |-> (!cmdIsoOn && !cmdSlow && 32'(cmdRow) < NEAR_ROWS)); // R2
  AST_FAR_SLOW: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd1) |-> (cmdIsoOn && cmdSlow && 32'(cmdRow) >= NEAR_ROWS)); // R3
  AST_LINK_FOLLOWS_FAR: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd2) |-> ($past(cmdValid && cmdOp == 2'd1) && cmdIsoOn)); // R4
  AST_PRE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cmdValid && cmdOp == 2'd3)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !cmdValid); // R9
  AST_TAKE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R9

endmodule

bind seg_row_cache_mgr seg_row_cache_mgr_chk #(
  .NEAR_ROWS(NEAR_ROWS), .FAR_ROWS(FAR_ROWS)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqRow(reqRow), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdRow(cmdRow),
  .cmdIsoOn(cmdIsoOn), .cmdSlow(cmdSlow), .done(done)
);

// File: tb/test_seg_row_cache_mgr.sv
module test_seg_row_cache_mgr;

  localparam int NR = 32, FR = 480, NL = 6, FL = 14, ME = 2;

  logic clk = 1'b0, rstN = 1'b0, modeWaitOnly = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [8:0] reqRow = '0;
  logic reqReady, cmdValid, cmdIsoOn, cmdSlow, done, doneHit;
  logic [1:0] cmdOp;
  logic [8:0] cmdRow;

  int nChecks = 0, nFail = 0, cycles = 0;

  // reference model of the tag store
  int mTag [NR];
  bit mVal [NR];
  int mAge [NR];
  bit mMark [FR];

  seg_row_cache_mgr i_seg_row_cache_mgr (
    .clk(clk), .rstN(rstN), .modeWaitOnly(modeWaitOnly), .reqValid(reqValid),
    .reqReady(reqReady), .reqRow(reqRow), .reqWrite(reqWrite),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdRow(cmdRow), .cmdIsoOn(cmdIsoOn),
    .cmdSlow(cmdSlow), .done(done), .doneHit(doneHit)
  );

  always #10 clk = ~clk;

  task automatic finishRun();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int findHit(int row);
    for (int s = 0; s < NR; s++) if (mVal[s] && mTag[s] == row) return s;
    return -1;
  endfunction

  function automatic int lruSlot();
    for (int s = 0; s < NR; s++) if (mAge[s] == 0) return s;
    return 0;
  endfunction

  function automatic void touch(int slot);
    for (int s = 0; s < NR; s++) if (mAge[s] > mAge[slot]) mAge[s]--;
    mAge[slot] = NR - 1;
  endfunction

  task automatic runTxn(int row, bit wr, bit ov, int nextRow, bit nextWr);
    int h, v, eN, eOp0, eRow0, eSlot, eLat, k, nAct, doneK, preK, nPre;
    bit eHit, ins, busyReady, gotDone, eIso0;
    string rq, rqSlot;
    int aOp [2], aRow [2], aK [2];
    bit aIso [2], aSlow [2];
    // expected behaviour from the model
    h = findHit(row);
    eSlot = 0;
    if (h >= 0) begin
      eHit = 1'b1;
      eSlot = h;
      if (!wr) begin
        eN = 1; eOp0 = 0; eRow0 = h; eLat = NL; rq = "R2";
      end else begin
        eN = 2; eOp0 = 1; eRow0 = NR + row; eLat = FL + ME; rq = "R8";
      end
      rqSlot = "R10";
      touch(h);
    end else begin
      eHit = 1'b0;
      ins = !modeWaitOnly || mMark[row];
      mMark[row] = 1'b0;
      eOp0 = 1; eRow0 = NR + row;
      rqSlot = modeWaitOnly ? "R7" : "R6";
      if (ins) begin
        v = lruSlot();
        mTag[v] = row; mVal[v] = 1'b1; touch(v);
        eSlot = v; eN = 2; eLat = FL + ME; rq = "R4";
      end else begin
        eN = 1; eLat = FL; rq = modeWaitOnly ? "R7" : "R3";
      end
    end
    if (ov) mMark[row] = 1'b1;
    eIso0 = (eOp0 == 1);
    // drive and wait for acceptance
    reqValid = 1'b1; reqRow = 9'(row); reqWrite = wr;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    if (ov) begin
      reqRow = 9'(nextRow); reqWrite = nextWr;
    end else begin
      reqValid = 1'b0;
    end
    k = 0; nAct = 0; doneK = -1; preK = -1; nPre = 0;
    busyReady = 1'b0; gotDone = 1'b0;
    while (!gotDone && k < 60) begin
      if (reqReady) busyReady = 1'b1;
      if (cmdValid) begin
        if (cmdOp == 2'd3) begin
          nPre++; preK = k;
        end else begin
          if (nAct < 2) begin
            aOp[nAct] = cmdOp; aRow[nAct] = cmdRow; aK[nAct] = k;
            aIso[nAct] = cmdIsoOn; aSlow[nAct] = cmdSlow;
          end
          nAct++;
        end
      end
      if (done) begin
        gotDone = 1'b1; doneK = k; eHit = eHit; 
        chk(doneHit == eHit, eHit ? "R2" : "R3", "doneHit", doneHit, eHit);
      end
      @(negedge clk);
      k++;
    end
    chk(nAct == eN, rq, "activation count", nAct, eN);
    if (nAct >= 1) begin
      chk(aOp[0] == eOp0 && aK[0] == 0, rq, "first op", aOp[0], eOp0);
      chk(aRow[0] == eRow0, rq, "first row", aRow[0], eRow0);
      chk(aIso[0] == eIso0 && aSlow[0] == eIso0, eIso0 ? "R3" : "R2", "iso/latency class",
          aIso[0], eIso0);
    end
    if (eN == 2 && nAct == 2) begin
      chk(aOp[1] == 2 && aK[1] == 1 && aIso[1] && aSlow[1], "R4", "link step", aOp[1], 2);
      chk(aRow[1] == eSlot, rqSlot, "destination slot", aRow[1], eSlot);
    end
    chk(doneK == eLat, rq, "latency", doneK, eLat);
    chk(nPre == 1 && preK == doneK, "R5", "precharge count at done", nPre, 1);
    chk(!busyReady, "R9", "ready while busy", busyReady, 0);
    chk(!done, "R5", "done pulse width", done, 0);
  endtask

  int rRow [400];
  bit rWr [400];
  bit rOv [400];

  initial begin
    for (int s = 0; s < NR; s++) begin mVal[s] = 1'b0; mTag[s] = 0; mAge[s] = s; end
    for (int r = 0; r < FR; r++) mMark[r] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);
    chk(cmdValid == 1'b0, "R1", "no command after reset", cmdValid, 0);
    chk(done == 1'b0, "R1", "no done after reset", done, 0);

    // R1/R6: fills go to slots in reset LRU order
    for (int r = 0; r < NR; r++) runTxn(r, 1'b0, 1'b0, 0, 1'b0);
    runTxn(5, 1'b0, 1'b0, 0, 1'b0);    // R2 read hit
    runTxn(6, 1'b1, 1'b0, 0, 1'b0);    // R8 write hit
    runTxn(40, 1'b0, 1'b0, 0, 1'b0);   // R6 evicts slot 0
    runTxn(0, 1'b0, 1'b0, 0, 1'b0);    // R6 row 0 missed again
    runTxn(5, 1'b0, 1'b0, 0, 1'b0);    // R10 row 5 still cached

    // R7: wait-only policy
    modeWaitOnly = 1'b1;
    runTxn(100, 1'b0, 1'b0, 0, 1'b0);  // not marked: no fill
    runTxn(100, 1'b0, 1'b0, 0, 1'b0);  // still a miss
    runTxn(101, 1'b0, 1'b1, 102, 1'b0);// marks 101
    runTxn(102, 1'b0, 1'b0, 0, 1'b0);
    runTxn(101, 1'b0, 1'b0, 0, 1'b0);  // marked: filled
    runTxn(101, 1'b0, 1'b0, 0, 1'b0);  // now a hit
    runTxn(102, 1'b1, 1'b0, 0, 1'b0);  // write miss, unmarked

    // constrained random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      rRow[i] = int'($urandom % 48);
      rWr[i]  = ($urandom % 4) == 0;
      rOv[i]  = ($urandom % 3) == 0;
    end
    rOv[399] = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (i % 100 == 0 && !reqValid) modeWaitOnly = (i / 100) % 2 == 1;
      runTxn(rRow[i], rWr[i], rOv[i], (i < 399) ? rRow[i+1] : 0,
             (i < 399) ? rWr[i+1] : 1'b0);
    end
    finishRun();
  end

endmodule